// File: doc/BRIEF.md
# Two-Wire EEPROM Random-Read Master

This block is a master for a two-wire serial bus. It fetches a run of consecutive bytes from a 2 KB serial EEPROM by performing a random-address read. A host pulses `start_i` with an 11-bit byte offset and a byte count. The block then drives the clock line and the data line itself. The data line is open-drain style, so it is represented by a value and an output-enable. Each byte that comes back is presented on `data_o` together with a one-cycle `valid_o` strobe. At the end the block gives a single-cycle `done_o`. If the device refuses any of the addressing bytes, the block gives a single-cycle `error_o` instead.

The transfer has a fixed sequence of steps. First a bus-recovery step drives both lines low and then issues a stop condition. Next come a start condition, a write-direction select byte that carries offset bits 10:8, and the low offset byte. Then a repeated start, a read-direction select byte, the data bytes, and a closing stop. Every pin change is followed by a hold of `2*SETTLE_CYC` system clocks. This hold covers the settle time on both sides of the change, and it sets the bus rate.

Top module: `eeprom_rd_master`

## Requirements
- R1: Out of reset, and whenever the block is not busy, `scl_o` is 1 and `sda_oe_o` is 0 (data line released). `done_o`, `error_o` and `valid_o` are 0.
- R2: Each transfer first drives the clock low, then the data low, then raises the clock, then raises the data. The data rise while the clock is high is the first stop condition. Only after this does the first start condition follow.
- R3: The master sends three addressing bytes, MSB first. The first is `{4'b1010, offset[10:8], 1'b0}`. The second is `offset[7:0]`. Then comes a repeated start, followed by `{4'b1010, offset[10:8], 1'b1}`.
- R4: The data bytes are shifted in MSB first. They are delivered on `data_o`, each with a one-cycle `valid_o`, in address order, and `count_i` bytes are delivered in total.
- R5: After each received byte the master drives an acknowledge bit. It drives 0 after every byte except the last, and 1 after the last one.
- R6: If the device leaves the acknowledge bit of any addressing byte at 1, the master stops sending. It issues a stop condition and pulses `error_o` for one cycle, never together with `done_o`. The pulse comes exactly `(11 + 36*(k+1) + (k==2 ? 4 : 0)) * 2*SETTLE_CYC` cycles after the start was accepted, where k is the index (0 to 2) of the refused byte.
- R7: A successful transfer ends with a stop condition. It then pulses `done_o` for one cycle, exactly `(123 + 36*count) * 2*SETTLE_CYC` cycles after the start was accepted.
- R8: A start with `count_i == 0` pulses `done_o` in the next cycle. In that case the bus lines are not touched and the block does not become busy.
- R9: While `busy_o` is 1, `start_i` is ignored. The running transfer keeps its latched offset and count.
- R10: Pin changes occur only at multiples of `2*SETTLE_CYC` cycles from the start of the transfer. During a transfer, `sda_oe_o` only changes while `scl_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse; taken only when idle |
| offset_i | input | 11 | First byte address to read |
| count_i | input | CNT_W | Number of bytes to read |
| sda_i | input | 1 | Sensed level of the data line |
| scl_o | output | 1 | Clock line level |
| sda_o | output | 1 | Data value driven when enabled |
| sda_oe_o | output | 1 | Data line output-enable (0 = released) |
| data_o | output | 8 | Last byte read |
| valid_o | output | 1 | One-cycle strobe for `data_o` |
| done_o | output | 1 | One-cycle pulse on successful completion |
| error_o | output | 1 | One-cycle pulse on refused addressing byte |
| busy_o | output | 1 | Transfer in progress |

## Verification
Each transfer is a fixed list of pin steps, and each step lasts `2*SETTLE_CYC` cycles. As a result, `done_o` falls due exactly `(123+36n)` steps after the accepted start, and `error_o` falls due after the step count given for the refused byte. `done_o` for a zero count falls due one cycle after the start. The bench counts clock edges from the edge that took the start to the edge that raised the pulse, and it compares that count with the formula. It samples on the falling clock edge and checks the following falling edge to confirm the pulse lasts only one cycle. The bytes, acknowledges and conditions on the bus are judged by a device model in the bench at the clock-line edges where they are due, and the bytes read are matched in order against a scoreboard queue.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;
  localparam int ADDR_W = 11;
  localparam int HI_W   = ADDR_W - 8;
  localparam logic [3:0] DEV_CODE = 4'hA;

  typedef enum logic [2:0] {
    ST_IDLE, ST_INIT, ST_START, ST_TX, ST_RX, ST_STOP
  } st_e;

  function automatic logic [7:0] dev_sel(input logic [HI_W-1:0] hi, input logic rd);
    return {DEV_CODE, hi, rd};
  endfunction
endpackage

// File: rtl/eeprom_rd_timer.sv
module eeprom_rd_timer #(
  parameter int HOLD = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int TW = (HOLD > 1) ? $clog2(HOLD) : 1;
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (restart_i)      cnt_q <= TW'(HOLD - 1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - TW'(1);
  end

  assign tick_o = (cnt_q == '0);
endmodule

// File: rtl/eeprom_rd_shift.sv
module eeprom_rd_shift #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (shift_i) q_o <= {q_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/eeprom_rd_master.sv
module eeprom_rd_master
  import eeprom_rd_pkg::*;
#(
  parameter int SETTLE_CYC = 250,
  parameter int CNT_W      = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [ADDR_W-1:0]   offset_i,
  input  logic [CNT_W-1:0]    count_i,
  input  logic                sda_i,
  output logic                scl_o,
  output logic                sda_o,
  output logic                sda_oe_o,
  output logic [7:0]          data_o,
  output logic                valid_o,
  output logic                done_o,
  output logic                error_o,
  output logic                busy_o
);
  localparam int HOLD = 2 * SETTLE_CYC;

  st_e               st_q, st_n;
  logic [3:0]        bit_q, bit_n;   // 0..7 data bits, 8 = acknowledge bit
  logic [1:0]        ph_q, ph_n;
  logic [1:0]        hdr_q, hdr_n;   // 0 select-write, 1 address low, 2 select-read
  logic [ADDR_W-1:0] off_q;
  logic [CNT_W-1:0]  left_q;
  logic              nack_q;
  logic              scl_q, sda_q, oe_q;
  logic              done_q, err_q, valid_q;
  logic              tick, busy, go, zero, adv, enter, last_ph, shift_en;
  logic [7:0]        tx_byte;

  assign busy    = (st_q != ST_IDLE);
  assign go      = !busy && start_i && (count_i != '0);
  assign zero    = !busy && start_i && (count_i == '0);
  assign adv     = busy && tick;
  assign enter   = go || adv;
  assign last_ph = (st_q == ST_STOP) ? (ph_q == 2'd2) : (ph_q == 2'd3);

  eeprom_rd_timer #(.HOLD(HOLD)) i_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(enter), .tick_o(tick)
  );

  // sample read data while the clock is high (end of phase 1)
  assign shift_en = adv && (st_q == ST_RX) && (bit_q != 4'd8) && (ph_q == 2'd1);

  eeprom_rd_shift #(.W(8)) i_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .shift_i(shift_en), .bit_i(sda_i), .q_o(data_o)
  );

  always_comb begin
    st_n  = st_q;
    bit_n = bit_q;
    ph_n  = ph_q;
    hdr_n = hdr_q;
    if (go) begin
      st_n  = ST_INIT;
      bit_n = '0;
      ph_n  = '0;
      hdr_n = '0;
    end else if (adv) begin
      if (!last_ph) begin
        ph_n = ph_q + 2'd1;
      end else begin
        ph_n = '0;
        unique case (st_q)
          ST_INIT:  st_n = ST_START;
          ST_START: begin st_n = ST_TX; bit_n = '0; end
          ST_TX: begin
            if (bit_q != 4'd8)       bit_n = bit_q + 4'd1;
            else if (nack_q)         st_n  = ST_STOP;
            else if (hdr_q == 2'd0)  begin hdr_n = 2'd1; bit_n = '0; end
            else if (hdr_q == 2'd1)  begin hdr_n = 2'd2; st_n = ST_START; end
            else                     begin st_n = ST_RX; bit_n = '0; end
          end
          ST_RX: begin
            if (bit_q != 4'd8)              bit_n = bit_q + 4'd1;
            else if (left_q == CNT_W'(1))   st_n  = ST_STOP;
            else                            bit_n = '0;
          end
          ST_STOP: st_n = ST_IDLE;
          default: st_n = ST_IDLE;
        endcase
      end
    end
  end

  assign tx_byte = (hdr_n == 2'd1) ? off_q[7:0]
                                   : dev_sel(off_q[ADDR_W-1:8], hdr_n == 2'd2);

  // pin step applied on entry to each phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      oe_q  <= 1'b0;
    end else if (enter) begin
      unique case (st_n)
        ST_IDLE: oe_q <= 1'b0;
        ST_INIT:
          unique case (ph_n)
            2'd0:    begin scl_q <= 1'b0; oe_q <= 1'b1; end
            2'd1:    sda_q <= 1'b0;
            2'd2:    scl_q <= 1'b1;
            default: sda_q <= 1'b1;
          endcase
        ST_START:
          unique case (ph_n)
            2'd0:    begin sda_q <= 1'b1; oe_q <= 1'b1; end
            2'd1:    scl_q <= 1'b1;
            2'd2:    sda_q <= 1'b0;
            default: scl_q <= 1'b0;
          endcase
        ST_TX:
          unique case (ph_n)
            2'd0: begin
              if (bit_n == 4'd8) begin oe_q <= 1'b0; sda_q <= 1'b1; end
              else begin oe_q <= 1'b1; sda_q <= tx_byte[3'd7 - bit_n[2:0]]; end
            end
            2'd1:    scl_q <= 1'b1;
            2'd2:    scl_q <= 1'b0;
            default: sda_q <= 1'b0;
          endcase
        ST_RX:
          unique case (ph_n)
            2'd0: begin
              if (bit_n == 4'd8) begin oe_q <= 1'b1; sda_q <= (left_q == CNT_W'(1)); end
              else begin oe_q <= 1'b0; sda_q <= 1'b1; end
            end
            2'd1:    scl_q <= 1'b1;
            2'd2:    scl_q <= 1'b0;
            default: sda_q <= 1'b0;
          endcase
        default:
          unique case (ph_n)
            2'd0:    begin sda_q <= 1'b0; oe_q <= 1'b1; end
            2'd1:    scl_q <= 1'b1;
            default: sda_q <= 1'b1;
          endcase
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      bit_q   <= '0;
      ph_q    <= '0;
      hdr_q   <= '0;
      off_q   <= '0;
      left_q  <= '0;
      nack_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      bit_q <= bit_n;
      ph_q  <= ph_n;
      hdr_q <= hdr_n;
      if (go) begin
        off_q  <= offset_i;
        left_q <= count_i;
        nack_q <= 1'b0;
      end
      if (adv && st_q == ST_TX && bit_q == 4'd8 && ph_q == 2'd1) nack_q <= sda_i;
      if (adv && st_q == ST_RX && bit_q == 4'd8 && last_ph) left_q <= left_q - CNT_W'(1);
      done_q  <= zero || (adv && st_q == ST_STOP && last_ph && !nack_q);
      err_q   <= adv && st_q == ST_STOP && last_ph && nack_q;
      valid_q <= adv && st_q == ST_RX && bit_q == 4'd7 && last_ph;
    end
  end

  assign scl_o    = scl_q;
  assign sda_o    = sda_q;
  assign sda_oe_o = oe_q;
  assign valid_o  = valid_q;
  assign done_o   = done_q;
  assign error_o  = err_q;
  assign busy_o   = busy;
endmodule

// File: rtl/eeprom_rd_master_chk.sv
module eeprom_rd_master_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [CNT_W-1:0] count_i,
  input logic             scl_o,
  input logic             sda_oe_o,
  input logic             valid_o,
  input logic             done_o,
  input logic             error_o,
  input logic             busy_o
);
  p_idle_bus_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (scl_o && !sda_oe_o));

  p_oe_scl_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !$stable(sda_oe_o)) |-> !scl_o);

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_err_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> !error_o);

  p_err_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && error_o));

  p_zero_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && count_i == '0) |=> (done_o && !busy_o));

  p_valid_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> busy_o);
endmodule

bind eeprom_rd_master eeprom_rd_master_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .count_i(count_i),
  .scl_o(scl_o), .sda_oe_o(sda_oe_o), .valid_o(valid_o), .done_o(done_o),
  .error_o(error_o), .busy_o(busy_o)
);

// File: tb/test_eeprom_rd_master.sv
module test_eeprom_rd_master;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 2;
  localparam int HOLD       = 2 * SETTLE;
  localparam int CNT_W      = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [10:0]      offset_i = '0;
  logic [CNT_W-1:0] count_i = '0;
  logic             scl_o, sda_o, sda_oe_o, valid_o, done_o, error_o, busy_o;
  logic [7:0]       data_o;
  logic             s_low = 1'b0;
  wire              sda_line = sda_oe_o ? sda_o : !s_low;

  int n_tests = 0, n_fail = 0, cyc = 0;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  eeprom_rd_master #(.SETTLE_CYC(SETTLE), .CNT_W(CNT_W)) i_eeprom_rd_master (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .offset_i(offset_i),
    .count_i(count_i), .sda_i(sda_line), .scl_o(scl_o), .sda_o(sda_o),
    .sda_oe_o(sda_oe_o), .data_o(data_o), .valid_o(valid_o), .done_o(done_o),
    .error_o(error_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_at(input logic [10:0] a);
    return 8'((int'(a) * 37 + 11) ^ (int'(a) >> 3));
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected byte", data_o, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(data_o == e, "R4 read byte", data_o, e);
      end
    end
  end

  // pin-step spacing monitor (R10)
  int viol = 0, last_chg = -1;
  logic [2:0] pv = 3'b110;
  always @(negedge clk) begin
    logic [2:0] cur;
    cur = {scl_o, sda_o, sda_oe_o};
    if (!busy_o) last_chg = -1;
    else if (cur != pv) begin
      if (last_chg >= 0 && ((cyc - last_chg) % HOLD) != 0) viol++;
      last_chg = cyc;
    end
    pv = cur;
  end

  // EEPROM device model
  logic [10:0] exp_off = '0;
  int exp_n = 0, nack_at = -1, starts = 0, stops = 0;
  int s_mode = 0, s_bit = 0, s_rxb = 0, s_sent = 0;
  logic [7:0] s_sh = '0, s_byte;
  logic [2:0] s_hi = '0;
  logic [10:0] s_ptr = '0;
  logic s_mack = 1'b0, s_nacked = 1'b0, s_to_send = 1'b0;
  logic pscl = 1'b1, psda = 1'b1;

  always @(scl_o or sda_line) begin
    if (scl_o && pscl && psda && !sda_line) begin
      starts++; s_mode = 1; s_bit = 0; s_low = 1'b0;
    end else if (scl_o && pscl && !psda && sda_line) begin
      stops++; s_mode = 0; s_rxb = 0; s_low = 1'b0;
    end else if (scl_o && !pscl) begin
      if (s_mode == 1) begin
        if (s_bit < 8) begin s_sh = {s_sh[6:0], sda_line}; s_bit++; end
        else s_bit = 9;
      end else if (s_mode == 2) begin
        if (s_bit < 8) s_bit++;
        else begin
          s_mack = sda_line;
          chk(s_mack == (s_sent == exp_n - 1), "R5 master ack bit", s_mack, s_sent == exp_n - 1);
          s_bit = 9;
        end
      end
    end else if (!scl_o && pscl) begin
      if (s_mode == 1) begin
        if (s_bit == 8) begin
          case (s_rxb)
            0: begin
              chk(s_sh == {4'hA, exp_off[10:8], 1'b0}, "R3 write select byte", s_sh, {4'hA, exp_off[10:8], 1'b0});
              s_hi = s_sh[3:1];
            end
            1: begin
              chk(s_sh == exp_off[7:0], "R3 address low byte", s_sh, exp_off[7:0]);
              s_ptr = {s_hi, s_sh};
            end
            default: chk(s_sh == {4'hA, exp_off[10:8], 1'b1}, "R3 read select byte", s_sh, {4'hA, exp_off[10:8], 1'b1});
          endcase
          s_nacked  = (s_rxb == nack_at);
          s_to_send = (s_rxb == 2);
          s_low     = !s_nacked;
        end else if (s_bit == 9) begin
          s_low = 1'b0; s_bit = 0; s_rxb++;
          if (s_nacked) s_mode = 0;
          else if (s_to_send) begin
            s_mode = 2; s_sent = 0; s_byte = mem_at(s_ptr); s_low = !s_byte[7];
          end
        end
      end else if (s_mode == 2) begin
        if (s_bit >= 1 && s_bit <= 7) begin
          s_byte = mem_at(s_ptr); s_low = !s_byte[7 - s_bit];
        end else if (s_bit == 8) s_low = 1'b0;
        else if (s_bit == 9) begin
          if (!s_mack) begin
            s_ptr++; s_sent++; s_bit = 0; s_byte = mem_at(s_ptr); s_low = !s_byte[7];
          end else s_mode = 0;
        end
      end
    end
    pscl = scl_o;
    psda = sda_line;
  end

  // driver: pushes expected bytes, starts a transfer, checks its end
  task automatic xfer(input logic [10:0] off, input int n, input int nk, input string tag);
    int t0, w, ops;
    exp_off = off; exp_n = n; nack_at = nk; starts = 0; stops = 0; viol = 0;
    if (nk < 0) for (int i = 0; i < n; i++) exp_q.push_back(mem_at(11'((int'(off) + i) % 2048)));
    @(negedge clk);
    start_i = 1'b1; offset_i = off; count_i = CNT_W'(n);
    @(negedge clk);
    start_i = 1'b0;
    t0 = cyc;
    w = 0;
    while (!(done_o || error_o) && w < 20000) begin @(negedge clk); w++; end
    if (w >= 20000) chk(1'b0, {tag, " watchdog"}, w, 0);
    if (nk < 0) begin
      ops = 123 + 36 * n;
      chk(done_o && !error_o, {tag, " R7 done pulse"}, {done_o, error_o}, 2);
      chk(cyc - t0 == ops * HOLD, {tag, " R7 done latency"}, cyc - t0, ops * HOLD);
      chk(starts == 2 && stops == 2, {tag, " R2 R3 start/stop count"}, starts * 16 + stops, 34);
      chk(exp_q.size() == 0, {tag, " R4 all bytes delivered"}, exp_q.size(), 0);
    end else begin
      ops = 11 + 36 * (nk + 1) + (nk == 2 ? 4 : 0);
      chk(error_o && !done_o, {tag, " R6 error pulse"}, {done_o, error_o}, 1);
      chk(cyc - t0 == ops * HOLD, {tag, " R6 error latency"}, cyc - t0, ops * HOLD);
      chk(stops == 2 && starts == (nk == 2 ? 2 : 1), {tag, " R6 stop after refusal"}, starts * 16 + stops, (nk == 2 ? 2 : 1) * 16 + 2);
    end
    @(negedge clk);
    chk(!done_o && !error_o && !busy_o, {tag, " R7 single-cycle pulse"}, {done_o, error_o, busy_o}, 0);
    chk(viol == 0, {tag, " R10 step spacing"}, viol, 0);
    chk(scl_o && !sda_oe_o, {tag, " R1 bus released"}, {scl_o, sda_oe_o}, 2);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(scl_o && !sda_oe_o && !busy_o && !done_o && !error_o && !valid_o, "R1 reset state",
        {scl_o, sda_oe_o, busy_o, done_o, error_o, valid_o}, 6'b100000);

    xfer(11'h000, 1, -1, "single byte");
    xfer(11'h5A3, 4, -1, "four bytes");
    xfer(11'h7FE, 3, -1, "wrap run");

    // R8: zero count
    starts = 0; stops = 0;
    @(negedge clk);
    start_i = 1'b1; offset_i = 11'h100; count_i = '0;
    @(negedge clk);
    start_i = 1'b0;
    chk(done_o && !busy_o, "R8 zero count done next cycle", {done_o, busy_o}, 2);
    chk(scl_o && !sda_oe_o, "R8 bus untouched", {scl_o, sda_oe_o}, 2);
    @(negedge clk);
    chk(!done_o && starts == 0 && stops == 0, "R8 no bus activity", starts + stops + done_o, 0);

    xfer(11'h2C4, 2, 0, "refuse select");
    xfer(11'h2C4, 2, 1, "refuse address");
    xfer(11'h6F0, 2, 2, "refuse read select");

    // R9: start during a transfer is ignored
    fork
      xfer(11'h3B1, 4, -1, "busy ignore R9");
      begin
        repeat (300) @(negedge clk);
        start_i = 1'b1; offset_i = 11'h044; count_i = CNT_W'(1);
        @(negedge clk);
        start_i = 1'b0;
      end
    join
    repeat (20) @(negedge clk);
    chk(!busy_o && exp_q.size() == 0, "R9 no second transfer", busy_o, 0);

    xfer(11'h0FF, 2, -1, "page cross");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule